// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter used as an operating-system heartbeat. Software programs a reload value, picks a tick source (every core clock cycle, or a synchronous one-cycle strobe from a slower reference), and enables the counter. Each time the count runs out, the block raises a sticky flag. If interrupt generation is enabled, it also drives a single-cycle request toward the interrupt controller. The counter then starts over from the reload value.

Software sees four word registers through a plain read/write port. The registers hold the control settings and the flag, the reload value, the live count, and a fixed calibration constant. Reading the control word consumes the flag. Any write to the live count restarts the period. A reload value of zero makes the counter fire once and then stop.

Top module: `systick_timer`

## Requirements
- R1: After reset the control word, the reload value and the flag are zero, the current value reads 0 and `tick_irq` is low.
- R2: The control word has these fields: bit 0 is run enable, bit 1 is interrupt enable, and bit 2 is the source select (1 = every clock cycle, 0 = `ref_tick` strobes). Bit 16 is the expiry flag. A write changes only bits [2:0]. The flag and all other bits are unaffected and read as their state (other bits 0).
- R3: Setting run enable from 0 to 1 loads the count from the reload value. Each selected tick then decrements the count. The tick that finds the count at 0 expires the period and reloads. A period is therefore reload+1 ticks.
- R4: An expiry always sets the flag. `tick_irq` is high for exactly one cycle after the expiring edge, and only when interrupt enable is 1.
- R5: A read of the control word returns the flag as bit 16 and clears it afterwards. A new expiry in the same cycle wins over the clear.
- R6: A write of any data to the current-value register reloads the count from the reload value and clears the flag. The reload suppresses a tick in the same cycle.
- R7: If the reload value is 0 when a period expires, run enable clears itself and counting stops.
- R8: The current value reads as 0 while run enable is 0. While running, it reads 0 during the final tick of each period, before the reload.
- R9: The calibration register reads the constant 10000 (decimal) and ignores writes.
- R10: Register byte offsets are 0x10 control, 0x14 reload, 0x18 current and 0x1C calibration. Other offsets read 0. The reload register keeps bits [23:0], and its upper bits read 0.
- R11: With source select 0 the count moves only on cycles where `ref_tick` is 1. Changing the source select while running does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Synchronous one-cycle reference tick strobe |
| reg_addr | input | 12 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; qualifies read side effects |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick_irq | output | 1 | One-cycle expiry interrupt request |

## Verification
The bench reads the live count on successive cycles across a period boundary. This shows the 0 read in the expiring tick, which a design that reloaded one tick early would skip. It also spaces interrupt pulses reload+1 cycles apart, so an off-by-one period shows up as drifting pulses. A reload of zero must give exactly one pulse and a cleared enable; a design that kept running would keep pulsing. Other scenarios pull the live count back mid-period with a write, flip the tick source mid-count (a design that restarted there would read the reload value again), and read the flag twice to show that it clears on the first read.

// File: rtl/systick_pkg.sv
// Shared constants of the tick timer: register offsets and control bit positions.
// Assumes byte addressing with word-aligned registers.
package systick_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CUR    = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_CAL    = 12'h01C;

    localparam int BIT_RUN  = 0;
    localparam int BIT_INT  = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;
endpackage

// File: rtl/systick_count.sv
// Count engine: holds the live count, decrements on each qualified tick,
// reloads on expiry or on a restart request. Assumes restart has priority
// over a tick arriving in the same cycle.
module systick_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;

    // Detects the tick that ends a period.
    always_comb begin
        at_zero = (count == '0);
        expire  = run && tick && at_zero && !restart;
    end

    // Holds, decrements or reloads the live count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= reload;
        end else if (run && tick) begin
            if (at_zero) count <= reload;
            else         count <= count - 1'b1;
        end
    end

    // R3: a non-final tick moves the count down by one
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !restart && count != '0) |=> (count == $past(count) - 1'b1));

    // R6: a restart loads the reload value
    p_restart_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == $past(reload)));

    // R11: without a qualified tick the count holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(run && tick)) |=> $stable(count));
endmodule

// File: rtl/systick_regs.sv
// Register block: decodes the four word registers, keeps the control bits,
// the sticky flag and the reload value, and forms the interrupt pulse.
// Assumes reg_rdata is sampled in the same cycle as reg_rd.
module systick_regs
    import systick_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic              run,
    output logic              src_core,
    output logic              restart,
    output logic [CNT_W-1:0]  reload,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_irq
);
    logic int_en;
    logic flag;
    logic wr_ctrl, wr_reload, wr_cur, rd_ctrl;

    // Decodes access strobes and the restart request.
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
        wr_reload = reg_wr && (reg_addr == OFS_RELOAD);
        wr_cur    = reg_wr && (reg_addr == OFS_CUR);
        rd_ctrl   = reg_rd && (reg_addr == OFS_CTRL);
        restart   = wr_cur || (wr_ctrl && reg_wdata[BIT_RUN] && !run);
    end

    // Control bits: software writes win over the zero-reload self stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            int_en   <= 1'b0;
            src_core <= 1'b0;
        end else if (wr_ctrl) begin
            run      <= reg_wdata[BIT_RUN];
            int_en   <= reg_wdata[BIT_INT];
            src_core <= reg_wdata[BIT_SRC];
        end else if (expire && reload == '0) begin
            run      <= 1'b0;
        end
    end

    // Sticky expiry flag; a fresh expiry beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (expire)            flag <= 1'b1;
        else if (rd_ctrl || wr_cur) flag <= 1'b0;
    end

    // Reload value, low CNT_W bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= '0;
        else if (wr_reload) reload <= reg_wdata[CNT_W-1:0];
    end

    // One-cycle interrupt request on an enabled expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_irq <= 1'b0;
        else        tick_irq <= expire && int_en;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[BIT_RUN]  = run;
                reg_rdata[BIT_INT]  = int_en;
                reg_rdata[BIT_SRC]  = src_core;
                reg_rdata[BIT_FLAG] = flag;
            end
            OFS_RELOAD: reg_rdata[CNT_W-1:0] = reload;
            OFS_CUR:    reg_rdata[CNT_W-1:0] = run ? count : '0;
            OFS_CAL:    reg_rdata = DATA_W'(CAL_VALUE);
            default:    reg_rdata = '0;
        endcase
    end

    // R4: an enabled expiry yields a pulse and a set flag
    p_irq_on_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && int_en) |=> (tick_irq && flag));

    // R4: the request stays quiet when interrupts are disabled
    p_no_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !int_en) |=> !tick_irq);

    // R5: a control read without a new expiry clears the flag
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !expire) |=> !flag);

    // R7: expiry with zero reload stops counting
    p_zero_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload == '0 && !wr_ctrl) |=> !run);
endmodule

// File: rtl/systick_timer.sv
// Top of the tick timer: selects the tick source and joins the register
// block to the count engine. Assumes ref_tick is synchronous to clk.
module systick_timer
    import systick_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_irq
);
    logic             run, src_core, restart, expire, tick;
    logic [CNT_W-1:0] reload, count;

    // Selects the decrement qualifier.
    always_comb tick = src_core ? 1'b1 : ref_tick;

    systick_regs #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .count(count), .expire(expire),
        .run(run), .src_core(src_core), .restart(restart), .reload(reload),
        .reg_rdata(reg_rdata), .tick_irq(tick_irq)
    );

    systick_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .restart(restart),
        .reload(reload), .count(count), .expire(expire)
    );

    // R4: the request is never longer than one cycle
    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq || $past(expire));
endmodule

// File: tb/sim_systick_timer.sv
module sim_systick_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CTRL = 12'h010, A_REL = 12'h014,
                            A_CUR = 12'h018, A_CAL = 12'h01C;

    logic        clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tick_irq;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    systick_timer u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tick_irq(tick_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Tasks are entered just after a falling edge; each consumes one rising edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_REL, v);  chk("R1 reload", v, 0);
        rd(A_CUR, v);  chk("R1 current", v, 0);
        chk("R1 irq", {31'b0, tick_irq}, 0);
    endtask

    task automatic t_period();
        logic [31:0] v;
        wr(A_REL, 3);
        wr(A_CTRL, 7);
        rd(A_CUR, v); chk("R3 load", v, 3);
        rd(A_CUR, v); chk("R3 dec", v, 2);
        rd(A_CUR, v); chk("R3 dec", v, 1);
        rd(A_CUR, v); chk("R8 zero tick", v, 0);
        rd(A_CUR, v); chk("R3 reload", v, 3);
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            chk("R4 pulse spacing", {31'b0, tick_irq}, {31'b0, (i % 4) == 3});
        end
        wr(A_CTRL, 0);
        rd(A_CTRL, v); chk("R5 flag read", v, 32'h0001_0000);
        rd(A_CTRL, v); chk("R5 flag cleared", v, 0);
        rd(A_CUR, v);  chk("R8 disabled", v, 0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        wr(A_REL, 2);
        wr(A_CTRL, 5);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R4 masked", {31'b0, tick_irq}, 0);
        end
        wr(A_CTRL, 0);
        rd(A_CTRL, v); chk("R4 flag without irq", v, 32'h0001_0000);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(A_REL, 1);
        wr(A_CTRL, 5);
        repeat (4) @(negedge clk);
        wr(A_REL, 50);
        wr(A_CUR, 32'h00AB_CDEF);
        rd(A_CTRL, v); chk("R6 flag cleared", v, 5);
        rd(A_CUR, v);  chk("R6 restarted", v, 49);
        wr(A_CTRL, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(A_REL, 0);
        wr(A_CTRL, 7);
        @(negedge clk);
        chk("R7 single pulse", {31'b0, tick_irq}, 1);
        rd(A_CTRL, v); chk("R7 self stop", v, 32'h0001_0006);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 no more pulses", {31'b0, tick_irq}, 0);
        end
        rd(A_CUR, v); chk("R8 stopped", v, 0);
    endtask

    task automatic t_ref();
        logic [31:0] v;
        wr(A_REL, 3);
        wr(A_CTRL, 3);
        repeat (5) @(negedge clk);
        rd(A_CUR, v); chk("R11 no strobe", v, 3);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        rd(A_CUR, v); chk("R11 strobe", v, 2);
        wr(A_CTRL, 7);
        rd(A_CUR, v); chk("R11 switch keeps count", v, 2);
        rd(A_CUR, v); chk("R11 core ticks", v, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        rd(A_CTRL, v);
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, v); chk("R2 only low bits", v, 0);
        wr(A_CTRL, 6);
        rd(A_CTRL, v); chk("R2 fields", v, 6);
        wr(A_CTRL, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        rd(A_CAL, v); chk("R9 calibration", v, 10000);
        wr(A_CAL, 32'h1234_5678);
        rd(A_CAL, v); chk("R9 write ignored", v, 10000);
        wr(A_REL, 32'hFFFF_FFFF);
        rd(A_REL, v); chk("R10 reload width", v, 32'h00FF_FFFF);
        rd(12'h020, v); chk("R10 unmapped", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_period();
        t_masked();
        t_restart();
        t_zero();
        t_ref();
        t_fields();
        t_map();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule